// File: doc/BRIEF.md
# D-Channel Priority Access Arbiter

This block decides when a terminal on a shared passive bus may place its layer-2 frame into the signalling D channel. Once per line frame it gets a D-bit slot strobe together with the echo (E) bit that the network side returned. It counts unbroken runs of echo ones. It keeps a high or low priority level for each of the two priority classes. It opens the channel only when the run is long enough for the class and level of the pending frame.

The layer-2 HDLC transmitter is serial and is paced by a fetch-enable output. When a request arrives, the block fetches bits until an opening flag sits in its transmit buffer, and then holds the fetch. Once access is granted it shifts out the frame one bit per slot and keeps fetching until the closing flag has arrived. While it sends, it checks every echo bit against the bit it sent just before that echo. On a mismatch it drops the frame at once.

A command pair turns the access algorithm on or off. With the algorithm off, a buffered frame goes out at the first slot, with neither counting nor echo compare.

Top module: `dch_access_arbiter`

## Requirements
- R1: While no frame is being transmitted, `d_o` is 1. It reads 1 after reset, and every slot strobe outside transmission drives a 1.
- R2: `req_i` is accepted only when the block is idle. On the cycle after acceptance `fetch_o` goes high. It stays high while bits are taken from `txd_i`, one on each rising edge with `fetch_o` high, until the last eight fetched bits equal the opening flag 01111110. It then stays low until access is granted.
- R3: With the algorithm on, transmission never starts unless the echo run, including the echo of the granting slot, is at least 8.
- R4: A class-1 request (`req_cls_i`=0) is granted at a run of 8 while class 1 is at its high level, and at 9 otherwise.
- R5: A class-2 request (`req_cls_i`=1) is granted at a run of 10 while class 2 is at its high level, and at 11 otherwise.
- R6: At the granting slot `d_o` becomes the leading 0 of the opening flag. At each later slot the next buffered bit goes out, in fetch order, and fetching resumes.
- R7: During transmission, if the echo given with a slot differs from the last bit sent, `d_o` becomes 1 from that slot on, `fetch_o` drops and `con_o` is set.
- R8: Fetching stops once the last bit of the closing flag has been taken. At the slot after the closing flag's final bit has gone out, `d_o` is 1 and `eom_o` is set.
- R9: A successful frame with the algorithm on drops its own class to the low level. Class 1 returns to high at an echo run of 9, and class 2 at a run of 11.
- R10: `acc_o` shows whether the algorithm is on. Its reset value is the `MASTER` parameter. `acc_off_i` turns it off and `acc_on_i` turns it on.
- R11: With the algorithm off, the first slot after the opening flag is buffered starts transmission whatever the echo is, and echo mismatches do not abort.
- R12: The echo run counter saturates at 11 and clears on any echo 0. `con_o` and `eom_o` stay set until a `clr_i` strobe.
- R13: A request pulse while a frame is pending or in flight has no effect, not even on the latched class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | One-cycle D-bit slot strobe, once per line frame |
| echo_i | input | 1 | Received echo bit, valid with `slot_i` |
| req_i | input | 1 | Transmit request pulse |
| req_cls_i | input | 1 | Priority class of the request: 0 class 1, 1 class 2 |
| txd_i | input | 1 | Serial data from the layer-2 transmitter |
| fetch_o | output | 1 | Shift enable toward the layer-2 transmitter |
| d_o | output | 1 | Outgoing D bit, updated at each slot strobe |
| acc_on_i | input | 1 | Command pulse: access algorithm on |
| acc_off_i | input | 1 | Command pulse: access algorithm off |
| clr_i | input | 1 | Clear strobe for the sticky status flags |
| con_o | output | 1 | Contention lost (sticky) |
| eom_o | output | 1 | End of message (sticky) |
| acc_o | output | 1 | Access algorithm currently on |

## Verification
The hardest situations to reach are the low-priority levels and their return to high. They only exist after a frame of that class has completed, or after an echo run of exactly the right length. The stimulus clears the run with a single echo 0 inside the waiting window and then feeds an exact number of ones, checking that `d_o` stays 1 one slot short of the threshold and carries the flag's 0 at the threshold. Contention is produced by echoing the complement of the bit just sent, both at the first sent bit and during a full frame with the algorithm off.

// File: rtl/dca_pkg.sv
`timescale 1ns/1ps
package dca_pkg;
    localparam int CNT_W    = 4;
    localparam int CNT_SAT  = 11;
    localparam int MIN_RUN  = 8;
    localparam int TH1_HI   = 8;
    localparam int TH1_LO   = 9;
    localparam int TH2_HI   = 10;
    localparam int TH2_LO   = 11;
    localparam int BACK1    = 9;
    localparam int BACK2    = 11;
    localparam int FLAG_LEN = 8;
    localparam logic [7:0] HDLC_FLAG = 8'b0111_1110;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREF = 2'd1,
        ST_WAIT = 2'd2,
        ST_SEND = 2'd3
    } dca_state_e;

    function automatic logic [CNT_W-1:0] access_thr(input logic cls2,
                                                    input logic hi1,
                                                    input logic hi2);
        if (cls2) return hi2 ? CNT_W'(TH2_HI) : CNT_W'(TH2_LO);
        return hi1 ? CNT_W'(TH1_HI) : CNT_W'(TH1_LO);
    endfunction
endpackage

// File: rtl/dca_echo_track.sv
`timescale 1ns/1ps
module dca_echo_track
    import dca_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             slot_i,
    input  logic             echo_i,
    input  logic             drop1_i,
    input  logic             drop2_i,
    output logic [CNT_W-1:0] run_nx_o,
    output logic             hi1_o,
    output logic             hi2_o
);
    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             hi1;
        logic             hi2;
    } trk_s;

    trk_s trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (slot_i) begin
            if (!echo_i) begin
                trk_d.run = '0;
            end else if (trk_q.run != CNT_W'(CNT_SAT)) begin
                trk_d.run = trk_q.run + 1'b1;
            end
            if (trk_d.run >= CNT_W'(BACK1)) trk_d.hi1 = 1'b1;
            if (trk_d.run >= CNT_W'(BACK2)) trk_d.hi2 = 1'b1;
        end
        if (drop1_i) trk_d.hi1 = 1'b0;
        if (drop2_i) trk_d.hi2 = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trk_q <= '{run: '0, hi1: 1'b1, hi2: 1'b1};
        else         trk_q <= trk_d;
    end

    assign run_nx_o = trk_d.run;
    assign hi1_o    = trk_q.hi1;
    assign hi2_o    = trk_q.hi2;

    p_run_sat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trk_q.run <= CNT_W'(CNT_SAT));
    p_run_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_i && !echo_i) |=> (trk_q.run == '0));
    p_back1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_i && !drop1_i && trk_q.run >= CNT_W'(BACK1) && echo_i) |=> hi1_o);
endmodule

// File: rtl/dca_bit_buf.sv
`timescale 1ns/1ps
module dca_bit_buf
    import dca_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         push_i,
    input  logic                         push_bit_i,
    input  logic                         pop_i,
    input  logic                         flush_i,
    input  logic                         load_flag_i,
    output logic                         head_o,
    output logic                         empty_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic [CW-1:0]    cnt;
    } buf_s;

    buf_s buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (pop_i && buf_d.cnt != '0) begin
            buf_d.bits = buf_d.bits >> 1;
            buf_d.cnt  = buf_d.cnt - 1'b1;
        end
        if (push_i && buf_d.cnt < CW'(DEPTH)) begin
            buf_d.bits[buf_d.cnt[IW-1:0]] = push_bit_i;
            buf_d.cnt = buf_d.cnt + 1'b1;
        end
        if (flush_i) buf_d.cnt = '0;
        if (load_flag_i) begin
            buf_d.bits = '0;
            buf_d.bits[FLAG_LEN-1:0] = HDLC_FLAG;
            buf_d.cnt = CW'(FLAG_LEN);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) buf_q <= '0;
        else         buf_q <= buf_d;
    end

    assign head_o  = buf_q.bits[0];
    assign empty_o = (buf_q.cnt == '0);
    assign full_o  = (buf_q.cnt == CW'(DEPTH));
    assign level_o = buf_q.cnt;

    p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full_o && !flush_i) |-> pop_i);
    p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);
endmodule

// File: rtl/dch_access_arbiter.sv
`timescale 1ns/1ps
module dch_access_arbiter
    import dca_pkg::*;
#(
    parameter int   DEPTH  = 16,
    parameter logic MASTER = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slot_i,
    input  logic echo_i,
    input  logic req_i,
    input  logic req_cls_i,
    input  logic txd_i,
    output logic fetch_o,
    output logic d_o,
    input  logic acc_on_i,
    input  logic acc_off_i,
    input  logic clr_i,
    output logic con_o,
    output logic eom_o,
    output logic acc_o
);
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        dca_state_e st;
        logic       cls;
        logic [7:0] win;
        logic       closed;
        logic       d;
        logic       last;
        logic       con;
        logic       eom;
        logic       acc;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic             push, pop, flush, load, drop1, drop2;
    logic             head, empty, full;
    logic [LW-1:0]    level;
    logic [CNT_W-1:0] run_nx;
    logic             hi1, hi2;
    logic [7:0]       win_in;
    logic             fetch;

    dca_echo_track i_track (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .slot_i   (slot_i),
        .echo_i   (echo_i),
        .drop1_i  (drop1),
        .drop2_i  (drop2),
        .run_nx_o (run_nx),
        .hi1_o    (hi1),
        .hi2_o    (hi2)
    );

    dca_bit_buf #(.DEPTH(DEPTH)) i_buf (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push),
        .push_bit_i  (txd_i),
        .pop_i       (pop),
        .flush_i     (flush),
        .load_flag_i (load),
        .head_o      (head),
        .empty_o     (empty),
        .full_o      (full),
        .level_o     (level)
    );

    assign win_in = {ctl_q.win[6:0], txd_i};
    assign fetch  = (ctl_q.st == ST_PREF) ||
                    (ctl_q.st == ST_SEND && !full && !ctl_q.closed);

    always_comb begin
        ctl_d = ctl_q;
        push  = 1'b0;
        pop   = 1'b0;
        flush = 1'b0;
        load  = 1'b0;
        drop1 = 1'b0;
        drop2 = 1'b0;
        if (clr_i) begin
            ctl_d.con = 1'b0;
            ctl_d.eom = 1'b0;
        end
        if (acc_on_i)       ctl_d.acc = 1'b1;
        else if (acc_off_i) ctl_d.acc = 1'b0;
        if (slot_i) ctl_d.d = 1'b1;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.st     = ST_PREF;
                    ctl_d.cls    = req_cls_i;
                    ctl_d.win    = 8'hFF;
                    ctl_d.closed = 1'b0;
                end
            end
            ST_PREF: begin
                ctl_d.win = win_in;
                if (win_in == HDLC_FLAG) begin
                    load      = 1'b1;
                    ctl_d.win = 8'hFF;
                    ctl_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (slot_i && (!ctl_q.acc ||
                    run_nx >= access_thr(ctl_q.cls, hi1, hi2))) begin
                    pop        = 1'b1;
                    ctl_d.d    = head;
                    ctl_d.last = head;
                    ctl_d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (fetch) begin
                    push      = 1'b1;
                    ctl_d.win = win_in;
                    if (win_in == HDLC_FLAG) ctl_d.closed = 1'b1;
                end
                if (slot_i) begin
                    if (ctl_q.acc && (echo_i != ctl_q.last)) begin
                        flush     = 1'b1;
                        ctl_d.d   = 1'b1;
                        ctl_d.con = 1'b1;
                        ctl_d.st  = ST_IDLE;
                    end else if (empty) begin
                        ctl_d.d    = 1'b1;
                        ctl_d.last = 1'b1;
                        if (ctl_q.closed) begin
                            ctl_d.eom = 1'b1;
                            ctl_d.st  = ST_IDLE;
                            drop1     = ctl_q.acc && !ctl_q.cls;
                            drop2     = ctl_q.acc &&  ctl_q.cls;
                        end
                    end else begin
                        pop        = 1'b1;
                        ctl_d.d    = head;
                        ctl_d.last = head;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, cls: 1'b0, win: 8'hFF, closed: 1'b0,
                       d: 1'b1, last: 1'b1, con: 1'b0, eom: 1'b0, acc: MASTER};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fetch_o = fetch;
    assign d_o     = ctl_q.d;
    assign con_o   = ctl_q.con;
    assign eom_o   = ctl_q.eom;
    assign acc_o   = ctl_q.acc;

    p_idle_ones_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_IDLE || ctl_q.st == ST_PREF) |-> d_o);
    p_flag_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_WAIT) |-> (level == LW'(FLAG_LEN) && !fetch_o));
    p_min_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_WAIT && ctl_d.st == ST_SEND && ctl_q.acc)
        |-> (run_nx >= CNT_W'(MIN_RUN)));
    p_lead_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_WAIT && ctl_d.st == ST_SEND) |=> !d_o);
    p_abort_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(con_o) |-> (d_o && !fetch_o));
    p_eom_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(eom_o) |-> (d_o && ctl_q.st != ST_SEND));
endmodule

// File: tb/test_dch_access_arbiter.sv
`timescale 1ns/1ps
module test_dch_access_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_i = 0, echo_i = 0, req_i = 0, req_cls_i = 0, txd_i = 1;
    logic acc_on_i = 0, acc_off_i = 0, clr_i = 0;
    logic fetch_o, d_o, con_o, eom_o, acc_o;

    int n_chk = 0, n_err = 0, n_fetched = 0;
    bit   exp_q[$];
    string tag_q[$];
    logic src_q[$];
    bit   pkt[22];
    bit   done = 0;

    always #2.5 clk = ~clk;

    dch_access_arbiter i_dch_access_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .slot_i(slot_i), .echo_i(echo_i),
        .req_i(req_i), .req_cls_i(req_cls_i), .txd_i(txd_i), .fetch_o(fetch_o),
        .d_o(d_o), .acc_on_i(acc_on_i), .acc_off_i(acc_off_i), .clr_i(clr_i),
        .con_o(con_o), .eom_o(eom_o), .acc_o(acc_o));

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the expected D bit for each slot strobe
    always @(posedge clk) begin
        if (rst_n && slot_i) begin
            #1;
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL scoreboard empty actual=%0d expected=none", d_o);
            end else begin
                chk(d_o, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // layer-2 serial source model
    always @(posedge clk) begin
        if (rst_n && fetch_o) begin
            #1;
            n_fetched++;
            if (src_q.size() > 0) void'(src_q.pop_front());
            txd_i = (src_q.size() > 0) ? src_q[0] : 1'b1;
        end
    end

    task automatic load_src();
        src_q = {};
        repeat (3) src_q.push_back(1'b1);
        for (int i = 0; i < 22; i++) src_q.push_back(pkt[i]);
        txd_i = src_q[0];
        n_fetched = 0;
    endtask

    task automatic slot_t(input bit e, input bit exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk); slot_i = 1; echo_i = e;
        @(negedge clk); slot_i = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_i = 1;
        @(negedge clk); clr_i = 0;
    endtask

    task automatic req_t(input bit cls);
        load_src();
        @(negedge clk); req_i = 1; req_cls_i = cls;
        @(negedge clk); req_i = 0;
        chk(fetch_o, 1'b1, "R2 fetch opens after request");
        for (int i = 0; i < 60 && fetch_o; i++) @(negedge clk);
        chk(fetch_o, 1'b0, "R2 fetch closes on opening flag");
        chk_int(n_fetched, 11, "R2 bits fetched up to opening flag");
    endtask

    // clear run with an echo 0, then n ones without grant, then one granting slot
    task automatic run_to_grant(input int n, input string tag);
        slot_t(1'b0, 1'b1, {tag, " run clear"});
        for (int i = 0; i < n; i++) slot_t(1'b1, 1'b1, {tag, " below threshold"});
        slot_t(1'b1, 1'b0, {tag, " grant sends flag 0 (R6)"});
    endtask

    task automatic abort_t(input string tag);
        slot_t(1'b1, 1'b1, {tag, " R7 mismatch forces 1"});
        chk(con_o, 1'b1, "R7 contention flag");
        chk(fetch_o, 1'b0, "R7 fetch inhibited");
        slot_t(1'b1, 1'b1, "R1 ones after abort");
        repeat (3) @(negedge clk);
        chk(con_o, 1'b1, "R12 contention flag sticky");
        pulse_clr();
        chk(con_o, 1'b0, "R12 contention flag cleared");
    endtask

    task automatic send_rest(input bit mism, input string tag);
        for (int i = 1; i < 22; i++)
            slot_t(mism ? ~pkt[i-1] : pkt[i-1], pkt[i], {tag, " R6 frame bit"});
        chk_int(n_fetched, 25, "R8 fetch stops after closing flag");
        chk(fetch_o, 1'b0, "R8 fetch low after closing flag");
        slot_t(mism ? ~pkt[21] : pkt[21], 1'b1, {tag, " R8 ones after closing flag"});
        chk(eom_o, 1'b1, "R8 end of message flag");
        chk(con_o, 1'b0, "R8 no contention on clean frame");
        pulse_clr();
        chk(eom_o, 1'b0, "R12 end of message cleared");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            pkt[i]    = (i == 0 || i == 7) ? 1'b0 : 1'b1;
            pkt[14+i] = pkt[i];
        end
        pkt[8] = 1; pkt[9] = 0; pkt[10] = 0; pkt[11] = 1; pkt[12] = 1; pkt[13] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(d_o, 1'b1, "R1 reset d");
        chk(fetch_o, 1'b0, "R2 reset fetch");
        chk(con_o, 1'b0, "R12 reset con");
        chk(eom_o, 1'b0, "R12 reset eom");
        chk(acc_o, 1'b1, "R10 reset algorithm on");
        repeat (3) slot_t(1'b1, 1'b1, "R1 idle ones");

        // A: class 1 at high level, grant at 8, full frame
        req_t(1'b0);
        run_to_grant(7, "R4 class1 high");
        send_rest(1'b0, "A");

        // B: class 1 now low, needs 9 (R9 drop)
        req_t(1'b0);
        run_to_grant(8, "R9 R4 class1 low");
        abort_t("B");

        // C: class 1 restored by the run of 9 in B
        req_t(1'b0);
        run_to_grant(7, "R9 class1 restored");
        abort_t("C");

        // D: class 2 high, grant at 10; request during wait ignored
        req_t(1'b1);
        @(negedge clk); req_i = 1; req_cls_i = 0;
        @(negedge clk); req_i = 0;
        chk(fetch_o, 1'b0, "R13 request while pending ignored");
        run_to_grant(9, "R5 R13 class2 high");
        send_rest(1'b0, "D");

        // E: class 2 low, needs 11
        req_t(1'b1);
        run_to_grant(10, "R9 R5 class2 low");
        abort_t("E");

        // F: class 2 restored by run of 11 in E
        req_t(1'b1);
        run_to_grant(9, "R9 class2 restored");
        abort_t("F");

        // H: counter saturates instead of wrapping
        repeat (20) slot_t(1'b1, 1'b1, "R1 idle long run");
        req_t(1'b1);
        slot_t(1'b1, 1'b0, "R12 saturated run grants at once");
        abort_t("H");

        // G: algorithm off
        @(negedge clk); acc_off_i = 1;
        @(negedge clk); acc_off_i = 0;
        chk(acc_o, 1'b0, "R10 algorithm off command");
        req_t(1'b0);
        slot_t(1'b0, 1'b0, "R11 start without echo run");
        send_rest(1'b1, "R11 no compare");
        @(negedge clk); acc_on_i = 1;
        @(negedge clk); acc_on_i = 0;
        chk(acc_o, 1'b1, "R10 algorithm on command");

        repeat (4) @(negedge clk);
        chk_int(exp_q.size(), 0, "scoreboard drained");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule